// File: doc/BRIEF.md
# Scatter-Gather Region Transfer Engine

This block moves a requested number of bytes between a local sector buffer and host memory by walking a table of region descriptors held in host memory. A start strobe supplies four things: the table base address, the number of descriptors, the total byte length and the direction. The engine then reads each descriptor and works out how many bytes that region carries. It moves the data one 32-bit word at a time, through a request/response host port and a single port of the buffer RAM.

A descriptor occupies 16 bytes. The engine reads two words of it: the region address at offset 0 and the flags/size word at offset 12. The walk ends when the remaining length reaches zero or when the descriptors run out, whichever comes first. The engine then pulses done for one cycle and reports the number of bytes actually moved. Alongside done it raises an interrupt-request flag if any region it processed had its completion-notify bit set.

Top module: `prd_sg_engine`

## Requirements
- R1: A start pulse seen while idle latches the parameters and raises busy in the following cycle. A start pulse while busy has no effect on the transfer in progress, its total or its data.
- R2: Descriptor k is read at table base + 16*k. The region address comes from the word at offset 0 (its low two bits are treated as zero) and the flags/size word from offset 12. The words at offsets 4 and 8 are never read, and the engine makes exactly two reads for each descriptor it processes.
- R3: A region holds size+1 bytes, where size is bits [21:0] of the flags/size word. Bits [30:22] do not change the count. The engine moves min(region bytes, remaining length) bytes for that region.
- R4: Data moves as 32-bit words with byte lane k carrying bits [8k+7:8k]. The last word of a region whose byte count is not a multiple of 4 enables only the valid low lanes, so destination bytes past the byte count are left unchanged.
- R5: The buffer word pointer starts at word 0 and advances by the rounded-up word count of each region, so every region begins on a buffer word boundary.
- R6: The walk stops as soon as the remaining length is zero or the descriptor count is used up, and no later descriptor is fetched. The reported total is the sum of the region transfers, which is less than the request when the descriptors run out.
- R7: A descriptor count of zero or a length of zero finishes with done and a total of zero, and no host request is made.
- R8: Done is high for exactly one cycle per transfer. The total stays on its output until the next accepted start.
- R9: The interrupt-request flag shown with done is 1 exactly when bit 31 was set in the flags/size word of at least one region that was processed. Unprocessed descriptors do not count.
- R10: Direction 1 reads the buffer and writes host memory. Direction 0 reads host memory and writes the buffer, and in direction 1 the buffer is never written.
- R11: During reset busy, done, the host request and the buffer write strobe are all low.
- R12: A host request, once raised, keeps its address and type until the host grants it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| to_host | input | 1 | 1: buffer to host, 0: host to buffer |
| tbl_base | input | ADDR_W | Byte address of the descriptor table |
| prd_count | input | CNT_W | Number of descriptors in the table |
| xfer_len | input | LEN_W | Total bytes requested |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| total_bytes | output | LEN_W | Bytes actually moved |
| irq_req | output | 1 | Completion-notify seen on a processed region |
| mem_req | output | 1 | Host request valid |
| mem_we | output | 1 | Host request is a write |
| mem_addr | output | ADDR_W | Host byte address (word aligned) |
| mem_wdata | output | 32 | Host write data |
| mem_be | output | 4 | Host write byte enables |
| mem_gnt | input | 1 | Host accepts the request this cycle |
| mem_rvalid | input | 1 | Host read data valid |
| mem_rdata | input | 32 | Host read data |
| buf_re | output | 1 | Buffer read, data one cycle later |
| buf_we | output | 1 | Buffer write |
| buf_addr | output | BUF_AW | Buffer word address |
| buf_wdata | output | 32 | Buffer write data |
| buf_be | output | 4 | Buffer write byte enables |
| buf_rdata | input | 32 | Buffer read data |

## Verification
A wrong chunk size or remaining-length count shows up at the end of the walk as a wrong total, and it also shows up in the destination bytes next to a region's last word. A wrong chunk size also corrupts those bytes or leaves them unwritten, and this is visible as soon as that region's last word is written. A wrong descriptor pointer or stop condition leads to reads outside the table, or to a different number of descriptor reads, so the bench counts every host read that falls in the table area. A stuck or wrongly sequenced state shows as a done pulse that is missing or longer than one cycle, or as a busy signal that ignores a fresh start.

// File: rtl/prd_sg_pkg.sv
package prd_sg_pkg;

  localparam int DESC_STRIDE = 16;
  localparam int FLAG_OFS    = 12;
  localparam int SIZE_W      = 22;
  localparam int NOTIFY_BIT  = 31;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_REQ,
    ST_ADR_RSP,
    ST_FLG_REQ,
    ST_FLG_RSP,
    ST_CHUNK,
    ST_BUF_RD,
    ST_BUF_LAT,
    ST_HOST_WR,
    ST_HOST_RD,
    ST_HOST_RSP,
    ST_BUF_WR,
    ST_NEXT,
    ST_DONE
  } walk_state_t;

  // Byte enables for the final word of a region, from the byte count mod 4.
  function automatic logic [3:0] tail_mask(input logic [1:0] rem_bytes);
    case (rem_bytes)
      2'd1:    tail_mask = 4'b0001;
      2'd2:    tail_mask = 4'b0011;
      2'd3:    tail_mask = 4'b0111;
      default: tail_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc
  import prd_sg_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  chunk_o,
  output logic [LEN_W-1:0]  words_o,
  output logic [3:0]        tail_be_o
);

  localparam int CW = ((LEN_W > SIZE_W + 1) ? LEN_W : SIZE_W + 1) + 1;

  logic [CW-1:0] region_bytes;
  logic [CW-1:0] rem_ext;

  always_comb begin
    region_bytes = CW'(size_i) + CW'(1);
    rem_ext      = CW'(rem_i);
    if (region_bytes < rem_ext) begin
      chunk_o = region_bytes[LEN_W-1:0];
    end else begin
      chunk_o = rem_i;
    end
    words_o   = {2'b00, chunk_o[LEN_W-1:2]} + LEN_W'(|chunk_o[1:0]);
    tail_be_o = tail_mask(chunk_o[1:0]);
  end

endmodule

// File: rtl/prd_word_cnt.sv
module prd_word_cnt #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             last_o
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | step_i;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step_i) begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == LEN_W'(1));

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cnt_q != '0)); // R4

endmodule

// File: rtl/prd_walk_ctrl.sv
module prd_walk_ctrl
  import prd_sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int CNT_W  = 16,
  parameter int BUF_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              to_host_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [CNT_W-1:0]  prd_count_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  total_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_be_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              buf_re_o,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [31:0]       buf_wdata_o,
  output logic [3:0]        buf_be_o,
  input  logic [31:0]       buf_rdata_i,
  output logic [SIZE_W-1:0] size_o,
  output logic [LEN_W-1:0]  rem_o,
  input  logic [LEN_W-1:0]  chunk_i,
  input  logic [3:0]        tail_be_i,
  output logic              cnt_load_o,
  output logic              cnt_step_o,
  input  logic              cnt_last_i
);

  walk_state_t       state_q, state_d;
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] desc_ptr_q, desc_ptr_d;
  logic [CNT_W-1:0]  desc_left_q, desc_left_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  total_q, total_d;
  logic [ADDR_W-1:0] host_ptr_q, host_ptr_d;
  logic [BUF_AW-1:0] buf_ptr_q, buf_ptr_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              notify_q, notify_d;
  logic              irq_q, irq_d;
  logic [3:0]        tail_be_q, tail_be_d;
  logic [31:0]       data_q, data_d;
  logic              word_done;
  logic [3:0]        word_be;

  assign word_be = cnt_last_i ? tail_be_q : 4'hF;

  // Next-state and datapath update.
  always_comb begin
    state_d     = state_q;
    dir_d       = dir_q;
    desc_ptr_d  = desc_ptr_q;
    desc_left_d = desc_left_q;
    rem_d       = rem_q;
    total_d     = total_q;
    host_ptr_d  = host_ptr_q;
    buf_ptr_d   = buf_ptr_q;
    size_d      = size_q;
    notify_d    = notify_q;
    irq_d       = irq_q;
    tail_be_d   = tail_be_q;
    data_d      = data_q;
    cnt_load_o  = 1'b0;
    word_done   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          dir_d       = to_host_i;
          desc_ptr_d  = tbl_base_i;
          desc_left_d = prd_count_i;
          rem_d       = xfer_len_i;
          total_d     = '0;
          irq_d       = 1'b0;
          buf_ptr_d   = '0;
          if ((prd_count_i == '0) || (xfer_len_i == '0)) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_ADR_REQ;
          end
        end
      end
      ST_ADR_REQ: if (mem_gnt_i) state_d = ST_ADR_RSP;
      ST_ADR_RSP: begin
        if (mem_rvalid_i) begin
          host_ptr_d = {mem_rdata_i[ADDR_W-1:2], 2'b00};
          state_d    = ST_FLG_REQ;
        end
      end
      ST_FLG_REQ: if (mem_gnt_i) state_d = ST_FLG_RSP;
      ST_FLG_RSP: begin
        if (mem_rvalid_i) begin
          size_d   = mem_rdata_i[SIZE_W-1:0];
          notify_d = mem_rdata_i[NOTIFY_BIT];
          state_d  = ST_CHUNK;
        end
      end
      ST_CHUNK: begin
        cnt_load_o = 1'b1;
        tail_be_d  = tail_be_i;
        rem_d      = rem_q - chunk_i;
        total_d    = total_q + chunk_i;
        irq_d      = irq_q | notify_q;
        state_d    = dir_q ? ST_BUF_RD : ST_HOST_RD;
      end
      ST_BUF_RD:  state_d = ST_BUF_LAT;
      ST_BUF_LAT: begin
        data_d  = buf_rdata_i;
        state_d = ST_HOST_WR;
      end
      ST_HOST_WR: begin
        if (mem_gnt_i) begin
          word_done = 1'b1;
          state_d   = cnt_last_i ? ST_NEXT : ST_BUF_RD;
        end
      end
      ST_HOST_RD: if (mem_gnt_i) state_d = ST_HOST_RSP;
      ST_HOST_RSP: begin
        if (mem_rvalid_i) begin
          data_d  = mem_rdata_i;
          state_d = ST_BUF_WR;
        end
      end
      ST_BUF_WR: begin
        word_done = 1'b1;
        state_d   = cnt_last_i ? ST_NEXT : ST_HOST_RD;
      end
      ST_NEXT: begin
        desc_left_d = desc_left_q - CNT_W'(1);
        desc_ptr_d  = desc_ptr_q + ADDR_W'(DESC_STRIDE);
        if ((rem_q == '0) || (desc_left_q == CNT_W'(1))) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_ADR_REQ;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    if (word_done) begin
      host_ptr_d = host_ptr_q + ADDR_W'(4);
      buf_ptr_d  = buf_ptr_q + BUF_AW'(1);
    end
  end

  assign cnt_step_o = word_done;

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dir_q       <= 1'b0;
      desc_ptr_q  <= '0;
      desc_left_q <= '0;
      rem_q       <= '0;
      total_q     <= '0;
      host_ptr_q  <= '0;
      buf_ptr_q   <= '0;
      size_q      <= '0;
      notify_q    <= 1'b0;
      irq_q       <= 1'b0;
      tail_be_q   <= '0;
      data_q      <= '0;
    end else begin
      state_q     <= state_d;
      dir_q       <= dir_d;
      desc_ptr_q  <= desc_ptr_d;
      desc_left_q <= desc_left_d;
      rem_q       <= rem_d;
      total_q     <= total_d;
      host_ptr_q  <= host_ptr_d;
      buf_ptr_q   <= buf_ptr_d;
      size_q      <= size_d;
      notify_q    <= notify_d;
      irq_q       <= irq_d;
      tail_be_q   <= tail_be_d;
      data_q      <= data_d;
    end
  end

  // Output decode from registered state.
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = host_ptr_q;
    mem_wdata_o = '0;
    mem_be_o    = 4'hF;
    buf_re_o    = 1'b0;
    buf_we_o    = 1'b0;
    buf_wdata_o = data_q;
    buf_be_o    = word_be;
    case (state_q)
      ST_ADR_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_ptr_q;
      end
      ST_FLG_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_ptr_q + ADDR_W'(FLAG_OFS);
      end
      ST_HOST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = data_q;
        mem_be_o    = word_be;
      end
      ST_HOST_RD: mem_req_o = 1'b1;
      ST_BUF_RD:  buf_re_o  = 1'b1;
      ST_BUF_WR:  buf_we_o  = 1'b1;
      default: ;
    endcase
  end

  assign buf_addr_o = buf_ptr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign total_o    = total_q;
  assign irq_o      = irq_q;
  assign size_o     = size_q;
  assign rem_o      = rem_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_TOHOST_NO_BUFWR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dir_q) |-> !buf_we_o); // R10
  AST_WRITE_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_be_o != 4'h0)); // R4
  AST_CHUNK_GROWS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHUNK) |=> (total_q > $past(total_q))); // R3
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state_q != ST_DONE) |=> $stable(dir_q)); // R1

endmodule

// File: rtl/prd_sg_engine.sv
module prd_sg_engine
  import prd_sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int CNT_W  = 16,
  parameter int BUF_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_host,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [CNT_W-1:0]  prd_count,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  total_bytes,
  output logic              irq_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              buf_re,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [31:0]       buf_wdata,
  output logic [3:0]        buf_be,
  input  logic [31:0]       buf_rdata
);

  logic [SIZE_W-1:0] size_w;
  logic [LEN_W-1:0]  rem_w;
  logic [LEN_W-1:0]  chunk_w;
  logic [LEN_W-1:0]  words_w;
  logic [3:0]        tail_be_w;
  logic              cnt_load_w;
  logic              cnt_step_w;
  logic              cnt_last_w;

  prd_walk_ctrl #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W),
    .BUF_AW (BUF_AW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .to_host_i    (to_host),
    .tbl_base_i   (tbl_base),
    .prd_count_i  (prd_count),
    .xfer_len_i   (xfer_len),
    .busy_o       (busy),
    .done_o       (done),
    .total_o      (total_bytes),
    .irq_o        (irq_req),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_be_o     (mem_be),
    .mem_gnt_i    (mem_gnt),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .buf_re_o     (buf_re),
    .buf_we_o     (buf_we),
    .buf_addr_o   (buf_addr),
    .buf_wdata_o  (buf_wdata),
    .buf_be_o     (buf_be),
    .buf_rdata_i  (buf_rdata),
    .size_o       (size_w),
    .rem_o        (rem_w),
    .chunk_i      (chunk_w),
    .tail_be_i    (tail_be_w),
    .cnt_load_o   (cnt_load_w),
    .cnt_step_o   (cnt_step_w),
    .cnt_last_i   (cnt_last_w)
  );

  prd_chunk_calc #(
    .LEN_W (LEN_W)
  ) u_calc (
    .size_i    (size_w),
    .rem_i     (rem_w),
    .chunk_o   (chunk_w),
    .words_o   (words_w),
    .tail_be_o (tail_be_w)
  );

  prd_word_cnt #(
    .LEN_W (LEN_W)
  ) u_wcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load_w),
    .load_val_i (words_w),
    .step_i     (cnt_step_w),
    .last_o     (cnt_last_w)
  );

endmodule

// File: tb/prd_sg_engine_tb.sv
module prd_sg_engine_tb;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 24;
  localparam int CNT_W  = 16;
  localparam int BUF_AW = 10;
  localparam int TBL    = 32'h20;

  typedef struct packed {
    logic        dir;
    logic [3:0]  cnt;
    logic [15:0] len;
    logic [31:0] f0;
    logic [31:0] f1;
    logic [31:0] f2;
  } vec_t;

  // dir, count, length, flags/size of descriptors 0..2
  localparam vec_t VECS [0:7] = '{
    '{1'b1, 4'd1, 16'd16,  32'd15,         32'd0,         32'd0},
    '{1'b1, 4'd3, 16'd100, 32'd31,         32'd31,        32'd63},
    '{1'b0, 4'd2, 16'd50,  32'd7,          32'd41,        32'd0},
    '{1'b1, 4'd2, 16'd200, 32'd9,          32'd12,        32'd0},
    '{1'b0, 4'd3, 16'd5,   32'd63,         32'h8000_0010, 32'h8000_0010},
    '{1'b0, 4'd2, 16'd30,  32'hC040_0009,  32'd19,        32'd0},
    '{1'b1, 4'd3, 16'd7,   32'd3,          32'h8000_0002, 32'd5},
    '{1'b0, 4'd1, 16'd256, 32'd255,        32'd0,         32'd0}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              to_host;
  logic [ADDR_W-1:0] tbl_base;
  logic [CNT_W-1:0]  prd_count;
  logic [LEN_W-1:0]  xfer_len;
  logic              busy, done, irq_req;
  logic [LEN_W-1:0]  total_bytes;
  logic              mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic [3:0]        mem_be;
  logic              buf_re, buf_we;
  logic [BUF_AW-1:0] buf_addr;
  logic [31:0]       buf_wdata, buf_rdata;
  logic [3:0]        buf_be;

  logic [7:0]  hmem [0:4095];
  logic [7:0]  bmem [0:4095];
  logic        init_req;
  logic        stall;
  logic [31:0] cur_f [0:2];
  int          fetch_cnt;
  logic [7:0]  gcnt;

  int checks = 0;
  int errors = 0;

  prd_sg_engine #(
    .ADDR_W (ADDR_W), .LEN_W (LEN_W), .CNT_W (CNT_W), .BUF_AW (BUF_AW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .to_host (to_host),
    .tbl_base (tbl_base), .prd_count (prd_count), .xfer_len (xfer_len),
    .busy (busy), .done (done), .total_bytes (total_bytes), .irq_req (irq_req),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_be (mem_be), .mem_gnt (mem_gnt),
    .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
    .buf_re (buf_re), .buf_we (buf_we), .buf_addr (buf_addr),
    .buf_wdata (buf_wdata), .buf_be (buf_be), .buf_rdata (buf_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] hpat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] bpat(input int a);
    return 8'(a * 3) ^ 8'h3C;
  endfunction

  // Host memory and buffer models (single writer for both arrays).
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (init_req) begin
      for (int a = 0; a < 4096; a++) begin
        hmem[a] <= hpat(a);
        bmem[a] <= bpat(a);
      end
      for (int i = 0; i < 3; i++) begin
        for (int k = 0; k < 4; k++) begin
          hmem[TBL + 16*i + k]      <= 8'((32'h200 + 32'h100*i) >> (8*k));
          hmem[TBL + 16*i + 4 + k]  <= 8'hFF;
          hmem[TBL + 16*i + 8 + k]  <= 8'h77;
          hmem[TBL + 16*i + 12 + k] <= 8'(cur_f[i] >> (8*k));
        end
      end
      fetch_cnt <= 0;
    end else begin
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) hmem[{mem_addr[11:2], 2'(k)}] <= mem_wdata[8*k +: 8];
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= {hmem[{mem_addr[11:2], 2'd3}], hmem[{mem_addr[11:2], 2'd2}],
                         hmem[{mem_addr[11:2], 2'd1}], hmem[{mem_addr[11:2], 2'd0}]};
          if (mem_addr[11:0] < 12'h200) fetch_cnt <= fetch_cnt + 1;
        end
      end
      if (buf_re)
        buf_rdata <= {bmem[{buf_addr, 2'd3}], bmem[{buf_addr, 2'd2}],
                      bmem[{buf_addr, 2'd1}], bmem[{buf_addr, 2'd0}]};
      if (buf_we)
        for (int k = 0; k < 4; k++)
          if (buf_be[k]) bmem[{buf_addr, 2'(k)}] <= buf_wdata[8*k +: 8];
    end
  end

  always @(negedge clk) begin
    if (!rst_n) gcnt <= '0;
    else gcnt <= gcnt + 8'd1;
    mem_gnt <= stall ? gcnt[0] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    int to = 0;
    seen = 1'b0;
    while (!done && to < 5000) begin
      @(negedge clk);
      to++;
    end
    seen = done;
  endtask

  task automatic run_vec(input int idx, input bit inject);
    vec_t v = VECS[idx];
    bit   seen;
    int   ndone, rem, bo, c, r4, bad_data, bad_tail, nproc, exp_tot;
    bit   exp_irq;
    logic [LEN_W-1:0] tot_at_done;
    cur_f[0] = v.f0; cur_f[1] = v.f1; cur_f[2] = v.f2;
    stall = idx[0];
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    to_host = v.dir; tbl_base = TBL; prd_count = CNT_W'(v.cnt); xfer_len = LEN_W'(v.len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (inject) begin
      repeat (4) @(negedge clk);
      to_host = ~v.dir; prd_count = 1; xfer_len = 4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(seen);
    check(seen, "R8", "done seen", seen, 1);
    tot_at_done = total_bytes;
    ndone = 0;
    for (int i = 0; i < 4; i++) begin
      if (done) ndone++;
      @(negedge clk);
    end
    check(ndone == 1, "R8", "done width", ndone, 1);
    check(total_bytes == tot_at_done, "R8", "total held", total_bytes, tot_at_done);
    // expected walk
    rem = v.len; bo = 0; bad_data = 0; bad_tail = 0; nproc = 0; exp_tot = 0; exp_irq = 0;
    for (int i = 0; i < v.cnt && rem > 0; i++) begin
      c  = int'(cur_f[i][21:0]) + 1;
      if (c > rem) c = rem;
      r4 = (c + 3) & ~3;
      exp_irq = exp_irq | cur_f[i][31];
      for (int b = 0; b < r4; b++) begin
        int ha = 32'h200 + 32'h100*i + b;
        if (b < c) begin
          if (hmem[ha] != bmem[bo + b]) bad_data++;
        end else if (v.dir) begin
          if (hmem[ha] != hpat(ha)) bad_tail++;
        end else begin
          if (bmem[bo + b] != bpat(bo + b)) bad_tail++;
        end
      end
      bo += r4; rem -= c; exp_tot += c; nproc++;
    end
    check(tot_at_done == LEN_W'(exp_tot), "R6", $sformatf("total vec %0d", idx), tot_at_done, exp_tot);
    check(bad_data == 0, v.dir ? "R10" : "R3", $sformatf("data bytes vec %0d (R5 offsets)", idx), bad_data, 0);
    check(bad_tail == 0, "R4", $sformatf("bytes past region vec %0d", idx), bad_tail, 0);
    check(fetch_cnt == 2*nproc, "R2", $sformatf("descriptor reads vec %0d", idx), fetch_cnt, 2*nproc);
    check(irq_req == exp_irq, "R9", $sformatf("irq vec %0d", idx), irq_req, exp_irq);
  endtask

  task automatic run_zero(input int cnt, input int len);
    int reqs = 0, ndone = 0;
    cur_f[0] = 32'd7; cur_f[1] = 0; cur_f[2] = 0;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    to_host = 1'b1; tbl_base = TBL; prd_count = CNT_W'(cnt); xfer_len = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (done) ndone++;
      if (mem_req) reqs++;
      @(negedge clk);
    end
    check(ndone == 1, "R7", $sformatf("done for count %0d len %0d", cnt, len), ndone, 1);
    check(reqs == 0, "R7", "no host request", reqs, 0);
    check(total_bytes == 0, "R7", "zero total", total_bytes, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; to_host = 1'b0; tbl_base = '0;
    prd_count = '0; xfer_len = '0; init_req = 1'b0; stall = 1'b0;
    cur_f[0] = 0; cur_f[1] = 0; cur_f[2] = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !buf_we, "R11", "reset outputs",
          {busy, done, mem_req, buf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) run_vec(i, 1'b0);
    run_vec(1, 1'b1); // R1: start while busy ignored
    run_zero(0, 50);  // R7
    run_zero(2, 0);   // R7
    run_vec(3, 1'b0); // R12 under stall with unaligned tails
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule